// File: doc/BRIEF.md
# DRAM Channel Bank State Tracker

This block observes the command bus of one channel of a wide-interface SDRAM from the controller or monitor side. On every rising clock edge it samples the per-rank clock enables and chip selects, the shared row/column/write strobes, the bank address and the address bus. It turns these into one decoded command per rank and keeps the state of every bank of every rank, along with the power state of each rank.

Each decoded command is reported one cycle later with its rank, bank, row and column fields. The row and column fields are masked to the widths that a static density selector picks. The auto-precharge qualifier (address bit 10 on reads and writes) and the short-preamble qualifier (address bit 11 on reads) are reported as flags. A command that is not allowed in the current state of its bank or rank leaves all state as it was, sets a sticky error flag and records its own code.

Power-down, self-refresh and deep power-down are entered when a rank's clock enable falls, and left when it rises. Precharge takes a fixed, parameterised number of cycles.

Top module: `dram_bank_tracker`

## Requirements
- R1: With clock enable high on the previous and the current edge, a rank whose active-low chip select is low decodes {ras_n,cas_n,we_n} as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 burst terminate, 111 no-op. The result appears one cycle later on cmd_code, with cmd_valid=1, cmd_rank and cmd_bank. The codes are 1 ACT, 2 RD, 3 RD+AP, 4 WR, 5 WR+AP, 6 PRE, 7 REF, 8 MRS, 9 BST, 10 self-refresh entry, 11 power-down entry, 12 deep power-down entry, 13 exit.
- R2: cmd_row is addr masked to 12, 13, 14, 15 or 15 bits for dens_sel 0, 1, 2, 3 and 4. cmd_col is addr masked to 7 bits, or to 8 bits for dens_sel 4. Values of dens_sel above 4 act as 4.
- R3: On a read or write, addr[10]=1 gives the auto-precharge code (3 or 5) and sets cmd_ap. cmd_sp equals addr[11] on reads and is 0 for every other command.
- R4: Bank state is 3 bits at bank_state[(rank*4+bank)*3 +: 3], with 0 idle, 1 active, 2 reading, 3 writing and 4 precharging. ACT is legal only from idle and moves the bank to active. RD and WR are legal from active, reading or writing, and move the bank to reading or writing. BST is legal only from reading or writing and returns the bank to active.
- R5: PRE, RD+AP and WR+AP are legal from active, reading or writing and move the bank to precharging. The bank reads 4 for PRE_CYCLES samples, starting with the one that follows the command, and then reads 0. An ACT issued PRE_CYCLES cycles after the precharge is illegal; one issued PRE_CYCLES+1 cycles after it is legal.
- R6: An illegal command leaves every bank and power state unchanged, sets err_flag, which stays set until reset, and loads err_code with the command's code.
- R7: REF and MRS are legal only when all banks of the rank are idle, and they change no bank state.
- R8: Power state is 3 bits at pwr_state[rank*3 +: 3], with 0 on, 1 idle power-down, 2 active power-down, 3 self-refresh and 4 deep power-down. A falling clock enable with a no-op or with chip select high enters state 1 if all banks are idle, and state 2 otherwise. Open banks keep their state.
- R9: A falling clock enable with chip select low and 001 on the strobes enters self-refresh (3); with 110 it enters deep power-down (4). Both need all banks idle and are illegal otherwise. A rising clock enable in any low-power state returns the rank to 0 and reports code 13.
- R10: No command is decoded while chip select is high and clock enable is steady, or while a rank's clock enable is low.
- R11: Ranks are tracked independently. When several ranks decode a command on the same edge, all of them update and the lowest rank is reported.
- R12: After reset, cmd_valid and err_flag are 0, every bank is idle and every rank is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dens_sel | input | 3 | Static density selector for row/column widths |
| cke | input | NUM_RANKS | Per-rank clock enable |
| cs_n | input | NUM_RANKS | Per-rank active-low chip select |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus |
| cmd_valid | output | 1 | A command was decoded on the previous edge |
| cmd_code | output | 4 | Decoded command code |
| cmd_rank | output | RANK_W | Rank of the reported command |
| cmd_bank | output | BA_W | Bank field |
| cmd_row | output | ADDR_W | Row field, masked |
| cmd_col | output | 8 | Column field, masked |
| cmd_ap | output | 1 | Auto-precharge requested |
| cmd_sp | output | 1 | Short read preamble requested |
| err_flag | output | 1 | Sticky illegal-command flag |
| err_code | output | 4 | Code of the latest illegal command |
| bank_state | output | NUM_RANKS*NUM_BANKS*3 | Packed bank states |
| pwr_state | output | NUM_RANKS*3 | Packed rank power states |

## Verification
On every cycle the assertions check the following:
- the error flag never clears;
- the qualifier flags appear only with the command codes that carry them;
- a quiet bus with a steady clock enable produces no command;
- a precharging bank leaves only to idle;
- a rank in idle power-down, self-refresh or deep power-down holds only idle banks.

Only the bench's scenarios can show the rest:
- the full legality table of every command against every bank state;
- the exact cycle on which precharge completes;
- the masked widths for each density setting;
- the choice between idle and active power-down;
- the lowest-rank priority when several ranks are selected at once.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_RDA  = 4'd3,
    C_WR   = 4'd4,
    C_WRA  = 4'd5,
    C_PRE  = 4'd6,
    C_REF  = 4'd7,
    C_MRS  = 4'd8,
    C_BST  = 4'd9,
    C_SREF = 4'd10,
    C_PDE  = 4'd11,
    C_DPD  = 4'd12,
    C_PDX  = 4'd13
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE   = 3'd0,
    B_ACTIVE = 3'd1,
    B_READ   = 3'd2,
    B_WRITE  = 3'd3,
    B_PRECH  = 3'd4
  } bank_e;

  typedef enum logic [2:0] {
    P_ON   = 3'd0,
    P_IPD  = 3'd1,
    P_APD  = 3'd2,
    P_SREF = 3'd3,
    P_DPD  = 3'd4
  } pwr_e;

  function automatic logic [4:0] row_bits(input logic [2:0] dens);
    case (dens)
      3'd0:    row_bits = 5'd12;
      3'd1:    row_bits = 5'd13;
      3'd2:    row_bits = 5'd14;
      default: row_bits = 5'd15;
    endcase
  endfunction

  function automatic logic [4:0] col_bits(input logic [2:0] dens);
    col_bits = (dens >= 3'd4) ? 5'd8 : 5'd7;
  endfunction

endpackage

// File: rtl/dbt_decode.sv
module dbt_decode
  import dbt_pkg::*;
(
  input  logic pwr_on,
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e code
);

  logic [2:0] rcw;
  assign rcw = {ras_n, cas_n, we_n};

  always_comb begin
    code = C_NOP;
    if (pwr_on) begin
      if (cke_prev && cke && !cs_n) begin
        case (rcw)
          3'b011:  code = C_ACT;
          3'b101:  code = a10 ? C_RDA : C_RD;
          3'b100:  code = a10 ? C_WRA : C_WR;
          3'b010:  code = C_PRE;
          3'b001:  code = C_REF;
          3'b000:  code = C_MRS;
          3'b110:  code = C_BST;
          default: code = C_NOP;
        endcase
      end else if (cke_prev && !cke) begin
        if (!cs_n && rcw == 3'b001)      code = C_SREF;
        else if (!cs_n && rcw == 3'b110) code = C_DPD;
        else                             code = C_PDE;
      end
    end else if (!cke_prev && cke) begin
      code = C_PDX;
    end
  end

endmodule

// File: rtl/dbt_bank.sv
module dbt_bank
  import dbt_pkg::*;
#(
  parameter int PRE_CYCLES = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  apply,
  input  cmd_e  cmd,
  output bank_e state
);

  localparam int CNT_W = $clog2(PRE_CYCLES + 1);

  bank_e            st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == B_PRECH) begin
      if (cnt_q == '0) st_d = B_IDLE;
      else             cnt_d = cnt_q - 1'b1;
    end
    if (apply) begin
      case (cmd)
        C_ACT, C_BST: st_d = B_ACTIVE;
        C_RD:         st_d = B_READ;
        C_WR:         st_d = B_WRITE;
        C_RDA, C_WRA, C_PRE: begin
          st_d  = B_PRECH;
          cnt_d = CNT_W'(PRE_CYCLES - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/dbt_rank.sv
module dbt_rank
  import dbt_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int PRE_CYCLES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic                      a10,
  input  logic [BA_W-1:0]           ba,
  output logic                      ev_valid,
  output cmd_e                      ev_code,
  output logic                      ev_bad,
  output pwr_e                      pwr,
  output logic [(1<<BA_W)*3-1:0]    banks
);

  localparam int NUM_BANKS = 1 << BA_W;

  logic                 cke_prev_q;
  pwr_e                 pwr_q, pwr_d;
  logic [2:0]           st [NUM_BANKS];
  logic [NUM_BANKS-1:0] apply;
  logic                 all_idle;
  logic                 legal;
  logic                 bank_cmd;
  bank_e                sel;

  dbt_decode u_dec (
    .pwr_on   (pwr_q == P_ON),
    .cke_prev (cke_prev_q),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .code     (ev_code)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_e bst;
    dbt_bank #(.PRE_CYCLES(PRE_CYCLES)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .apply (apply[b]),
      .cmd   (ev_code),
      .state (bst)
    );
    assign st[b]          = bst;
    assign banks[b*3 +: 3] = bst;
    assign apply[b]       = bank_cmd && legal && (ba == BA_W'(b));
  end

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++)
      if (st[b] != B_IDLE) all_idle = 1'b0;
  end

  assign sel      = bank_e'(st[ba]);
  assign ev_valid = (ev_code != C_NOP);
  assign bank_cmd = (ev_code inside {C_ACT, C_RD, C_RDA, C_WR, C_WRA, C_PRE, C_BST});

  always_comb begin
    case (ev_code)
      C_ACT:                            legal = (sel == B_IDLE);
      C_RD, C_RDA, C_WR, C_WRA, C_PRE:  legal = (sel inside {B_ACTIVE, B_READ, B_WRITE});
      C_BST:                            legal = (sel inside {B_READ, B_WRITE});
      C_REF, C_MRS, C_SREF, C_DPD:      legal = all_idle;
      default:                          legal = 1'b1;
    endcase
  end

  assign ev_bad = ev_valid && !legal;

  always_comb begin
    pwr_d = pwr_q;
    if (ev_valid && legal) begin
      case (ev_code)
        C_SREF:  pwr_d = P_SREF;
        C_DPD:   pwr_d = P_DPD;
        C_PDE:   pwr_d = all_idle ? P_IPD : P_APD;
        C_PDX:   pwr_d = P_ON;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b0;
      pwr_q      <= P_ON;
    end else begin
      cke_prev_q <= cke;
      pwr_q      <= pwr_d;
    end
  end

  assign pwr = pwr_q;

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dbt_pkg::*;
#(
  parameter int NUM_RANKS  = 4,
  parameter int BA_W       = 2,
  parameter int ADDR_W     = 15,
  parameter int PRE_CYCLES = 3,
  localparam int NUM_BANKS = 1 << BA_W,
  localparam int RANK_W    = $clog2(NUM_RANKS),
  localparam int COL_W     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [2:0]                      dens_sel,
  input  logic [NUM_RANKS-1:0]            cke,
  input  logic [NUM_RANKS-1:0]            cs_n,
  input  logic                            ras_n,
  input  logic                            cas_n,
  input  logic                            we_n,
  input  logic [BA_W-1:0]                 ba,
  input  logic [ADDR_W-1:0]               addr,
  output logic                            cmd_valid,
  output logic [3:0]                      cmd_code,
  output logic [RANK_W-1:0]               cmd_rank,
  output logic [BA_W-1:0]                 cmd_bank,
  output logic [ADDR_W-1:0]               cmd_row,
  output logic [COL_W-1:0]                cmd_col,
  output logic                            cmd_ap,
  output logic                            cmd_sp,
  output logic                            err_flag,
  output logic [3:0]                      err_code,
  output logic [NUM_RANKS*NUM_BANKS*3-1:0] bank_state,
  output logic [NUM_RANKS*3-1:0]          pwr_state
);

  logic [NUM_RANKS-1:0] ev_valid, ev_bad;
  cmd_e                 ev_code [NUM_RANKS];
  logic [RANK_W-1:0]    pick, bad_pick;
  logic                 any_v, any_bad;
  cmd_e                 code_sel;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    pwr_e pw;
    dbt_rank #(.BA_W(BA_W), .PRE_CYCLES(PRE_CYCLES)) u_rank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke[r]),
      .cs_n     (cs_n[r]),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .a10      (addr[10]),
      .ba       (ba),
      .ev_valid (ev_valid[r]),
      .ev_code  (ev_code[r]),
      .ev_bad   (ev_bad[r]),
      .pwr      (pw),
      .banks    (bank_state[r*NUM_BANKS*3 +: NUM_BANKS*3])
    );
    assign pwr_state[r*3 +: 3] = pw;
  end

  // lowest rank wins both the report and the error record
  always_comb begin
    pick     = '0;
    bad_pick = '0;
    any_v    = 1'b0;
    any_bad  = 1'b0;
    for (int r = NUM_RANKS - 1; r >= 0; r--) begin
      if (ev_valid[r]) begin pick = RANK_W'(r);     any_v   = 1'b1; end
      if (ev_bad[r])   begin bad_pick = RANK_W'(r); any_bad = 1'b1; end
    end
  end

  assign code_sel = ev_code[pick];

  // field masking by density selection
  logic [ADDR_W:0]     row_ones;
  logic [COL_W:0]      col_ones;
  logic [ADDR_W-1:0]   row_d;
  logic [COL_W-1:0]    col_d;
  logic                ap_d, sp_d, err_d;

  always_comb begin
    row_ones = ({{ADDR_W{1'b0}}, 1'b1} << row_bits(dens_sel)) - 1'b1;
    col_ones = ({{COL_W{1'b0}}, 1'b1} << col_bits(dens_sel)) - 1'b1;
    row_d    = addr & row_ones[ADDR_W-1:0];
    col_d    = addr[COL_W-1:0] & col_ones[COL_W-1:0];
    ap_d     = (code_sel == C_RDA) || (code_sel == C_WRA);
    sp_d     = ((code_sel == C_RD) || (code_sel == C_RDA)) && addr[11];
    err_d    = err_flag | any_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= C_NOP;
      cmd_rank  <= '0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_ap    <= 1'b0;
      cmd_sp    <= 1'b0;
      err_flag  <= 1'b0;
      err_code  <= C_NOP;
    end else begin
      cmd_valid <= any_v;
      err_flag  <= err_d;
      if (any_v) begin
        cmd_code <= code_sel;
        cmd_rank <= pick;
        cmd_bank <= ba;
        cmd_row  <= row_d;
        cmd_col  <= col_d;
        cmd_ap   <= ap_d;
        cmd_sp   <= sp_d;
      end
      if (any_bad) err_code <= ev_code[bad_pick];
    end
  end

endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int NUM_RANKS = 4,
  parameter int NUM_BANKS = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_RANKS-1:0]             cke,
  input logic [NUM_RANKS-1:0]             cs_n,
  input logic                             cmd_valid,
  input logic [3:0]                       cmd_code,
  input logic                             cmd_ap,
  input logic                             cmd_sp,
  input logic                             err_flag,
  input logic [NUM_RANKS*NUM_BANKS*3-1:0] bank_state,
  input logic [NUM_RANKS*3-1:0]           pwr_state
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R6

  AST_SP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sp) |-> (cmd_code == 4'd2 || cmd_code == 4'd3)); // R3

  AST_AP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ap) |-> (cmd_code == 4'd3 || cmd_code == 4'd5)); // R3

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n && $stable(cke)) |=> !cmd_valid); // R10

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_r
    AST_LOWPWR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state[r*3 +: 3] inside {3'd1, 3'd3, 3'd4})
        |-> (bank_state[r*NUM_BANKS*3 +: NUM_BANKS*3] == '0)); // R9
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      AST_PRECH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bank_state[(r*NUM_BANKS+b)*3 +: 3]) == 3'd4 &&
         bank_state[(r*NUM_BANKS+b)*3 +: 3] != 3'd4)
          |-> (bank_state[(r*NUM_BANKS+b)*3 +: 3] == 3'd0)); // R5
    end
  end

endmodule

bind dram_bank_tracker dbt_checker #(
  .NUM_RANKS (NUM_RANKS),
  .NUM_BANKS (NUM_BANKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cs_n       (cs_n),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .cmd_ap     (cmd_ap),
  .cmd_sp     (cmd_sp),
  .err_flag   (err_flag),
  .bank_state (bank_state),
  .pwr_state  (pwr_state)
);

// File: tb/dram_bank_tracker_tb.sv
module dram_bank_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  dens_sel;
  logic [3:0]  cke, cs_n;
  logic        ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [14:0] addr;
  logic        cmd_valid, cmd_ap, cmd_sp, err_flag;
  logic [3:0]  cmd_code, err_code;
  logic [1:0]  cmd_rank, cmd_bank;
  logic [14:0] cmd_row;
  logic [7:0]  cmd_col;
  logic [47:0] bank_state;
  logic [11:0] pwr_state;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_bank_tracker #(.PRE_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .dens_sel(dens_sel), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_rank(cmd_rank),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_ap(cmd_ap), .cmd_sp(cmd_sp), .err_flag(err_flag),
    .err_code(err_code), .bank_state(bank_state), .pwr_state(pwr_state)
  );

  function automatic int bk(int r, int b);
    return int'((bank_state >> ((r*4 + b)*3)) & 48'h7);
  endfunction

  function automatic int pw(int r);
    return int'((pwr_state >> (r*3)) & 12'h7);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    cs_n = '1; {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cke = '1; bus_idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one command on rank r; returns at the negedge after the sampling edge
  task automatic issue(int r, logic [2:0] rcw, int b, logic [14:0] a);
    cs_n[r] = 1'b0; {ras_n, cas_n, we_n} = rcw; ba = 2'(b); addr = a;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic cke_step(int r, logic lvl, logic cs, logic [2:0] rcw);
    cke[r] = lvl; cs_n[r] = cs; {ras_n, cas_n, we_n} = rcw;
    @(negedge clk);
    bus_idle();
  endtask

  function automatic logic [2:0] op_rcw(int c);
    case (c)
      0: return 3'b011;
      1, 2: return 3'b101;
      3, 4: return 3'b100;
      5: return 3'b010;
      6: return 3'b001;
      7: return 3'b000;
      default: return 3'b110;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = '1; dens_sel = 3'd2; bus_idle();
    do_reset();

    // R12 reset state
    chk("R12 cmd_valid", cmd_valid, 0);
    chk("R12 err_flag", err_flag, 0);
    chk("R12 bank_state", (bank_state == '0) ? 1 : 0, 1);
    chk("R12 pwr_state", (pwr_state == '0) ? 1 : 0, 1);

    // R1 R4 R5 R6 R7: every command against every open-row state of rank1 bank2
    for (int st = 0; st < 4; st++) begin
      for (int c = 0; c < 9; c++) begin
        int  exp_code, exp_st;
        bit  ok;
        do_reset();
        if (st >= 1) issue(1, 3'b011, 2, 15'd0);
        if (st == 2) issue(1, 3'b101, 2, 15'd0);
        if (st == 3) issue(1, 3'b100, 2, 15'd0);
        exp_code = c + 1;
        case (c)
          0:          ok = (st == 0);
          1,2,3,4,5:  ok = (st >= 1);
          6, 7:       ok = (st == 0);
          default:    ok = (st >= 2);
        endcase
        exp_st = st;
        if (ok) case (c)
          0, 8:    exp_st = 1;
          1:       exp_st = 2;
          3:       exp_st = 3;
          2, 4, 5: exp_st = 4;
          default: exp_st = st;
        endcase
        issue(1, op_rcw(c), 2, (c == 2 || c == 4) ? 15'h0400 : 15'h0000);
        chk("R1 code", cmd_code, exp_code);
        chk("R1 valid", cmd_valid, 1);
        chk("R1 rank", cmd_rank, 1);
        chk("R1 bank", cmd_bank, 2);
        chk("R4 R6 err_flag", err_flag, ok ? 0 : 1);
        if (!ok) chk("R6 err_code", err_code, exp_code);
        chk("R4 R5 R7 bank state", bk(1, 2), exp_st);
      end
    end

    // R5 precharge duration
    do_reset();
    issue(0, 3'b011, 0, 15'd0);
    issue(0, 3'b010, 0, 15'd0);
    chk("R5 prech start", bk(0, 0), 4);
    for (int j = 1; j <= P; j++) begin
      @(negedge clk);
      chk("R5 prech window", bk(0, 0), (j < P) ? 4 : 0);
    end
    do_reset();
    issue(0, 3'b011, 0, 15'd0);
    issue(0, 3'b010, 0, 15'd0);
    repeat (P - 1) @(negedge clk);
    issue(0, 3'b011, 0, 15'd0);
    chk("R5 early ACT err", err_flag, 1);
    do_reset();
    issue(0, 3'b011, 0, 15'd0);
    issue(0, 3'b010, 0, 15'd0);
    repeat (P) @(negedge clk);
    issue(0, 3'b011, 0, 15'd0);
    chk("R5 ACT after window err", err_flag, 0);
    chk("R5 ACT after window state", bk(0, 0), 1);

    // R2 R3 density widths with all-ones address
    for (int d = 0; d < 5; d++) begin
      int rw, cw;
      dens_sel = 3'(d);
      do_reset();
      rw = (d == 0) ? 12 : (d == 1) ? 13 : (d == 2) ? 14 : 15;
      cw = (d == 4) ? 8 : 7;
      issue(0, 3'b011, 1, 15'h7FFF);
      chk("R2 row", cmd_row, (1 << rw) - 1);
      issue(0, 3'b101, 1, 15'h7FFF);
      chk("R2 col", cmd_col, (1 << cw) - 1);
      chk("R3 rda code", cmd_code, 3);
      chk("R3 ap", cmd_ap, 1);
      chk("R3 sp", cmd_sp, 1);
    end
    dens_sel = 3'd2;

    // R3 qualifiers without auto-precharge
    do_reset();
    issue(0, 3'b011, 3, 15'd0);
    issue(0, 3'b100, 3, 15'h0800);
    chk("R3 wr code", cmd_code, 4);
    chk("R3 wr sp", cmd_sp, 0);
    chk("R3 wr ap", cmd_ap, 0);
    issue(0, 3'b101, 3, 15'h0800);
    chk("R3 rd code", cmd_code, 2);
    chk("R3 rd sp", cmd_sp, 1);
    chk("R3 rd ap", cmd_ap, 0);

    // R8 idle power-down, R10 commands ignored while cke low, exit reported
    do_reset();
    cke_step(0, 1'b0, 1'b1, 3'b111);
    chk("R8 ipd", pw(0), 1);
    chk("R8 pde code", cmd_code, 11);
    issue(0, 3'b011, 0, 15'd0);
    chk("R10 cke low valid", cmd_valid, 0);
    chk("R10 cke low bank", bk(0, 0), 0);
    cke_step(0, 1'b1, 1'b1, 3'b111);
    chk("R9 exit pwr", pw(0), 0);
    chk("R9 exit code", cmd_code, 13);

    // R8 active power-down keeps open bank
    do_reset();
    issue(0, 3'b011, 1, 15'd0);
    cke_step(0, 1'b0, 1'b1, 3'b111);
    chk("R8 apd", pw(0), 2);
    chk("R8 apd bank", bk(0, 1), 1);

    // R9 self-refresh and deep power-down
    do_reset();
    cke_step(3, 1'b0, 1'b0, 3'b001);
    chk("R9 sref", pw(3), 3);
    chk("R9 sref code", cmd_code, 10);
    cke_step(3, 1'b1, 1'b1, 3'b111);
    chk("R9 sref exit", pw(3), 0);
    cke_step(2, 1'b0, 1'b0, 3'b110);
    chk("R9 dpd", pw(2), 4);
    chk("R9 dpd code", cmd_code, 12);

    // R9 R6 self-refresh with open bank is illegal; error stays
    do_reset();
    issue(1, 3'b011, 0, 15'd0);
    cke_step(1, 1'b0, 1'b0, 3'b001);
    chk("R9 bad sref err", err_flag, 1);
    chk("R9 bad sref code", err_code, 10);
    chk("R9 bad sref pwr", pw(1), 0);
    chk("R9 bad sref bank", bk(1, 0), 1);
    cke[1] = 1'b1;
    repeat (2) @(negedge clk);
    issue(1, 3'b101, 0, 15'd0);
    chk("R6 sticky flag", err_flag, 1);
    chk("R6 sticky code", err_code, 10);

    // R10 strobes active with every chip select high
    do_reset();
    {ras_n, cas_n, we_n} = 3'b011;
    @(negedge clk);
    bus_idle();
    chk("R10 cs high valid", cmd_valid, 0);
    chk("R10 cs high banks", (bank_state == '0) ? 1 : 0, 1);

    // R11 two ranks at once, lowest reported; ranks independent
    do_reset();
    cs_n[2] = 1'b0;
    issue(0, 3'b011, 1, 15'd0);
    chk("R11 rank pick", cmd_rank, 0);
    chk("R11 rank0", bk(0, 1), 1);
    chk("R11 rank2", bk(2, 1), 1);
    chk("R11 rank1 untouched", bk(1, 1), 0);
    issue(3, 3'b011, 2, 15'd0);
    chk("R11 rank3 report", cmd_rank, 3);
    chk("R11 rank0 untouched", bk(0, 2), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule